// File: doc/BRIEF.md
# Three-Pin Scan Test Controller

This block lets a chip with only three test pins (a scan clock, a scan-in pin and a scan-out pin) run full-scan stuck-at tests. No scan enable pin exists, so the block makes the internal scan enable itself. It counts shift clocks against a programmed chain length. When the count is reached it drops scan enable for a capture window. The window ends in one of two ways: it runs for a programmed number of clocks, or it ends on a trigger level that the tester drives on the scan-in pin. The scan-in pin is otherwise idle during capture, so it can carry this trigger.

A configuration set is loaded once after reset. It holds the chain length, the capture length, the capture exit style, a chain selector and a request to enter scan mode. The selector connects one of several full-scan chains to the two data pins. The block also holds the pin-sharing wrapper. In functional use the scan-in pin feeds the core and the scan-out pin carries a core output. In scan mode the core input is forced low and the scan-out pin carries the selected chain's tail. The loaded setting holds until the next reset.

Top module: `tri_pin_scan_ctrl`

## Requirements
- R1: After reset, scan_en and scan_mode are 0, every chain_si bit is 0, pad_so equals func_so and func_in equals pad_si.
- R2: The first cycle with cfg_load high after reset captures all cfg_* inputs. Every later cfg_load is ignored until the next reset. A load with cfg_enter low leaves the block in functional use with scan_en held at 0.
- R3: scan_mode is 1 from the clock edge that accepts a load with cfg_enter high. scan_en rises one clock after scan_mode rises. scan_en is never 1 while scan_mode is 0.
- R4: Each shift phase keeps scan_en high for exactly cfg_len clocks. A value of 0 counts as 1. The counter restarts every time scan_en rises, so every shift phase has the same length.
- R5: With cfg_trig = 0 (timed capture), scan_en stays low for exactly cfg_cap clocks, where 0 counts as 1. It then rises again for the next shift phase.
- R6: With cfg_trig = 1 (triggered capture), scan_en stays low until pad_si is sampled high on a clock edge during capture. scan_en then rises on the following edge. A pad_si level sampled while shifting never ends a later capture.
- R7: cfg_sel value k (0 to NUM_CHAINS-1) connects pad_si only to chain_si[k] and drives pad_so from chain_tail[k]. Any other value connects no chain: chain_si is all 0 and pad_so is 0.
- R8: While scan_mode is 0, pad_so equals func_so and func_in equals pad_si. While scan_mode is 1, func_in is 0.
- R9: Once scan_mode is 1, it and the chain selection stay fixed until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock from the test pin |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_load | input | 1 | Load strobe for the configuration set |
| cfg_enter | input | 1 | Request scan mode on load |
| cfg_trig | input | 1 | Capture exit style: 1 triggered by pad_si, 0 timed |
| cfg_sel | input | SEL_W | Chain selector |
| cfg_len | input | LEN_W | Shift length in clocks |
| cfg_cap | input | CAP_W | Timed capture length in clocks |
| pad_si | input | 1 | Shared scan-in pin, also the capture trigger |
| pad_so | output | 1 | Shared scan-out pin |
| func_so | input | 1 | Core functional output for the scan-out pin |
| func_in | output | 1 | Gated functional copy of the scan-in pin |
| chain_tail | input | NUM_CHAINS | Last flop of each scan chain |
| chain_si | output | NUM_CHAINS | Head of each scan chain |
| scan_mode | output | 1 | Scan mode active |
| scan_en | output | 1 | Generated scan enable |

## Verification
Pin steering and functional gating are combinational, so the bench checks them in the same half cycle as the stimulus. scan_mode is due one edge after a load strobe, and scan_en rises one edge after that. In triggered capture, scan_en rises on the second edge after pad_si goes high, because the trigger is registered before the sequencer reads it. The bench drives inputs and samples outputs on falling edges. It measures shift and capture phase lengths by counting falling edges with scan_en at a given level, which keeps every expected count free of edge-order effects.

// File: rtl/scan3_pkg.sv
package scan3_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_CAPT  = 2'd2
    } phase_e;
endpackage

// File: rtl/scan3_cfg.sv
module scan3_cfg #(
    parameter int LEN_W = 16,
    parameter int CAP_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             enter_i,
    input  logic             trig_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [CAP_W-1:0] cap_i,
    output logic             mode_o,
    output logic             trig_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [LEN_W-1:0] len_o,
    output logic [CAP_W-1:0] cap_o
);
    typedef struct packed {
        logic             locked;
        logic             enter;
        logic             trig;
        logic [SEL_W-1:0] sel;
        logic [LEN_W-1:0] len;
        logic [CAP_W-1:0] cap;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i && !cfg_q.locked) begin
            cfg_d.locked = 1'b1;
            cfg_d.enter  = enter_i;
            cfg_d.trig   = trig_i;
            cfg_d.sel    = sel_i;
            cfg_d.len    = len_i;
            cfg_d.cap    = cap_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode_o = cfg_q.locked & cfg_q.enter;
    assign trig_o = cfg_q.trig;
    assign sel_o  = cfg_q.sel;
    assign len_o  = cfg_q.len;
    assign cap_o  = cfg_q.cap;
endmodule

// File: rtl/scan3_seq.sv
module scan3_seq
    import scan3_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CAP_W = 8,
    localparam int CNT_W = (LEN_W > CAP_W) ? LEN_W : CAP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             trig_mode_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [CAP_W-1:0] cap_i,
    input  logic             pad_si_i,
    output logic             scan_en_o
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             trig;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             shift_done;
    logic             cap_done;

    assign cnt_inc    = seq_q.cnt + CNT_W'(1);
    assign shift_done = cnt_inc >= CNT_W'(len_i);
    assign cap_done   = cnt_inc >= CNT_W'(cap_i);

    always_comb begin
        seq_d      = seq_q;
        // trigger is only armed while capturing
        seq_d.trig = pad_si_i & (seq_q.ph == PH_CAPT);
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (mode_i) begin
                    seq_d.ph  = PH_SHIFT;
                    seq_d.cnt = '0;
                end
            end
            PH_SHIFT: begin
                if (shift_done) begin
                    seq_d.ph  = PH_CAPT;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = cnt_inc;
                end
            end
            PH_CAPT: begin
                if (trig_mode_i) begin
                    if (seq_q.trig) begin
                        seq_d.ph  = PH_SHIFT;
                        seq_d.cnt = '0;
                    end
                end else if (cap_done) begin
                    seq_d.ph  = PH_SHIFT;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = cnt_inc;
                end
            end
            default: begin
                seq_d.ph  = PH_IDLE;
                seq_d.cnt = '0;
            end
        endcase
        if (!mode_i) begin
            seq_d.ph  = PH_IDLE;
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, cnt: '0, trig: 1'b0};
        else        seq_q <= seq_d;
    end

    assign scan_en_o = (seq_q.ph == PH_SHIFT);
endmodule

// File: rtl/scan3_wrap.sv
module scan3_wrap #(
    parameter int NUM_CHAINS = 3,
    parameter int SEL_W      = 2
) (
    input  logic                  mode_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic                  pad_si_i,
    input  logic                  func_so_i,
    input  logic [NUM_CHAINS-1:0] chain_tail_i,
    output logic [NUM_CHAINS-1:0] chain_si_o,
    output logic                  pad_so_o,
    output logic                  func_in_o
);
    logic tail_pick;

    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_head
        assign chain_si_o[g] = mode_i & (sel_i == SEL_W'(g)) & pad_si_i;
    end

    always_comb begin
        tail_pick = 1'b0;
        for (int i = 0; i < NUM_CHAINS; i++) begin
            if (sel_i == SEL_W'(i)) tail_pick = chain_tail_i[i];
        end
    end

    assign pad_so_o  = mode_i ? tail_pick : func_so_i;
    assign func_in_o = pad_si_i & ~mode_i;
endmodule

// File: rtl/tri_pin_scan_ctrl.sv
module tri_pin_scan_ctrl #(
    parameter int NUM_CHAINS = 3,
    parameter int LEN_W      = 16,
    parameter int CAP_W      = 8,
    localparam int SEL_W     = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS + 1) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic                  cfg_enter,
    input  logic                  cfg_trig,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [LEN_W-1:0]      cfg_len,
    input  logic [CAP_W-1:0]      cfg_cap,
    input  logic                  pad_si,
    output logic                  pad_so,
    input  logic                  func_so,
    output logic                  func_in,
    input  logic [NUM_CHAINS-1:0] chain_tail,
    output logic [NUM_CHAINS-1:0] chain_si,
    output logic                  scan_mode,
    output logic                  scan_en
);
    logic             trig_mode;
    logic [SEL_W-1:0] sel_q;
    logic [LEN_W-1:0] len_q;
    logic [CAP_W-1:0] cap_q;

    scan3_cfg #(.LEN_W(LEN_W), .CAP_W(CAP_W), .SEL_W(SEL_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cfg_load),
        .enter_i (cfg_enter),
        .trig_i  (cfg_trig),
        .sel_i   (cfg_sel),
        .len_i   (cfg_len),
        .cap_i   (cfg_cap),
        .mode_o  (scan_mode),
        .trig_o  (trig_mode),
        .sel_o   (sel_q),
        .len_o   (len_q),
        .cap_o   (cap_q)
    );

    scan3_seq #(.LEN_W(LEN_W), .CAP_W(CAP_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (scan_mode),
        .trig_mode_i (trig_mode),
        .len_i       (len_q),
        .cap_i       (cap_q),
        .pad_si_i    (pad_si),
        .scan_en_o   (scan_en)
    );

    scan3_wrap #(.NUM_CHAINS(NUM_CHAINS), .SEL_W(SEL_W)) u_wrap (
        .mode_i       (scan_mode),
        .sel_i        (sel_q),
        .pad_si_i     (pad_si),
        .func_so_i    (func_so),
        .chain_tail_i (chain_tail),
        .chain_si_o   (chain_si),
        .pad_so_o     (pad_so),
        .func_in_o    (func_in)
    );
endmodule

// File: rtl/scan3_chk.sv
module scan3_chk #(
    parameter int NUM_CHAINS = 3,
    parameter int SEL_W      = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scan_mode,
    input logic                  scan_en,
    input logic                  func_in,
    input logic [NUM_CHAINS-1:0] chain_si,
    input logic [SEL_W-1:0]      sel_q
);
    a_r3_no_enable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_mode |-> !scan_en);

    a_r3_enable_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_mode) |=> scan_en);

    a_r7_single_chain: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chain_si));

    a_r8_core_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        scan_mode |-> !func_in);

    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        scan_mode |=> scan_mode);

    a_r9_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        scan_mode |=> $stable(sel_q));
endmodule

bind tri_pin_scan_ctrl scan3_chk #(.NUM_CHAINS(NUM_CHAINS), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_mode (scan_mode),
    .scan_en   (scan_en),
    .func_in   (func_in),
    .chain_si  (chain_si),
    .sel_q     (sel_q)
);

// File: tb/sim_tri_pin_scan_ctrl.sv
module sim_tri_pin_scan_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int NV = 4;
    localparam int VLEN [NV] = '{3, 1, 6, 0};
    localparam int VCAP [NV] = '{2, 1, 4, 0};
    localparam int VSEL [NV] = '{0, 1, 2, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0, cfg_enter = 1'b0, cfg_trig = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [15:0] cfg_len = '0;
    logic [7:0] cfg_cap = '0;
    logic pad_si = 1'b0, func_so = 1'b0;
    logic [NCH-1:0] chain_tail = '0;
    logic pad_so, func_in, scan_mode, scan_en;
    logic [NCH-1:0] chain_si;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_pin_scan_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_enter(cfg_enter),
        .cfg_trig(cfg_trig), .cfg_sel(cfg_sel), .cfg_len(cfg_len), .cfg_cap(cfg_cap),
        .pad_si(pad_si), .pad_so(pad_so), .func_so(func_so), .func_in(func_in),
        .chain_tail(chain_tail), .chain_si(chain_si), .scan_mode(scan_mode),
        .scan_en(scan_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_load = 1'b0;
        pad_si = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_load(input logic en, input logic tr, input int sel,
                           input int len, input int cap);
        cfg_enter = en; cfg_trig = tr;
        cfg_sel = 2'(sel); cfg_len = 16'(len); cfg_cap = 8'(cap);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // count falling edges on which scan_en holds the given level
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (scan_en == lvl && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        do_reset();
        // R1 reset state
        pad_si = 1'b1; func_so = 1'b1; chain_tail = '1;
        #1;
        chk("R1 scan_en", scan_en, 0);
        chk("R1 scan_mode", scan_mode, 0);
        chk("R1 chain_si", chain_si, 0);
        chk("R1 pad_so", pad_so, 1);
        chk("R1 func_in", func_in, 1);
        pad_si = 1'b0; func_so = 1'b0; chain_tail = '0;

        // table of timed configurations
        for (int v = 0; v < NV; v++) begin
            int el, ec;
            el = (VLEN[v] == 0) ? 1 : VLEN[v];
            ec = (VCAP[v] == 0) ? 1 : VCAP[v];
            do_reset();
            @(negedge clk);
            do_load(1'b1, 1'b0, VSEL[v], VLEN[v], VCAP[v]);
            chk("R3 mode after load", scan_mode, 1);
            chk("R3 enable not yet", scan_en, 0);
            @(negedge clk);
            chk("R3 enable one clock later", scan_en, 1);
            run_len(1'b1, n); chk("R4 shift length", n, el);
            run_len(1'b0, n); chk("R5 capture length", n, ec);
            run_len(1'b1, n); chk("R4 second shift length", n, el);
            run_len(1'b0, n); chk("R5 second capture length", n, ec);
            pad_si = 1'b1; #1;
            chk("R7 chain head", chain_si, 1 << VSEL[v]);
            chk("R8 core input gated", func_in, 0);
            chain_tail = NCH'(1 << VSEL[v]); func_so = 1'b0; #1;
            chk("R7 tail to pin high", pad_so, 1);
            chain_tail = ~NCH'(1 << VSEL[v]); func_so = 1'b1; #1;
            chk("R7 tail to pin low", pad_so, 0);
            pad_si = 1'b0; chain_tail = '0; func_so = 1'b0;
        end

        // R6 triggered capture
        do_reset();
        @(negedge clk);
        do_load(1'b1, 1'b1, 0, 4, 1);
        @(negedge clk);
        pad_si = 1'b1;          // high through shift: must not end capture
        run_len(1'b1, n); chk("R4 shift length triggered", n, 4);
        pad_si = 1'b0;
        for (int k = 0; k < 6; k++) @(negedge clk);
        chk("R6 waits for trigger", scan_en, 0);
        pad_si = 1'b1;
        @(negedge clk);
        chk("R6 one edge after trigger", scan_en, 0);
        @(negedge clk);
        chk("R6 rises on second edge", scan_en, 1);
        pad_si = 1'b0;
        run_len(1'b1, n); chk("R4 shift after trigger", n, 4);

        // R2 second load ignored, R9 selection held
        do_reset();
        @(negedge clk);
        do_load(1'b1, 1'b0, 2, 3, 2);
        do_load(1'b1, 1'b0, 0, 7, 5);
        chain_tail = 3'b100; #1;
        chk("R2 later load ignored (sel)", pad_so, 1);
        chk("R9 mode held", scan_mode, 1);
        run_len(1'b1, n);
        run_len(1'b0, n); chk("R2 later load ignored (cap)", n, 2);
        run_len(1'b1, n); chk("R2 later load ignored (len)", n, 3);
        chain_tail = '0;

        // R2 load without scan request, R8 functional path
        do_reset();
        @(negedge clk);
        do_load(1'b0, 1'b0, 1, 2, 1);
        do_load(1'b1, 1'b0, 1, 2, 1);
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk("R2 no scan mode", scan_mode, 0);
        chk("R2 scan_en held low", scan_en, 0);
        pad_si = 1'b1; func_so = 1'b1; chain_tail = '0; #1;
        chk("R8 func_in follows pin", func_in, 1);
        chk("R8 pad_so follows core", pad_so, 1);
        chk("R8 no chain head", chain_si, 0);
        pad_si = 1'b0; func_so = 1'b0;

        // R7 out-of-range selector
        do_reset();
        @(negedge clk);
        do_load(1'b1, 1'b0, 3, 2, 1);
        pad_si = 1'b1; chain_tail = '1; func_so = 1'b1; #1;
        chk("R7 unused code no head", chain_si, 0);
        chk("R7 unused code pin low", pad_so, 0);
        pad_si = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule